// File: doc/BRIEF.md
# Histogram Static-Parameter Accumulator

This block turns the per-sample match pulses of a converter self-test sequencer into the static error figures of an analog-to-digital converter: offset, gain error, differential nonlinearity and integral nonlinearity. A single saturating two's-complement up/down counter does all the arithmetic. It serves as the histogram bin, as the subtractor of the ideal count, and as the running integrator across codes. The ideal per-code count is 2^P and the gain code range holds m = 2^Z codes, so every division by an ideal constant is a fixed binary-point placement rather than a divider.

The sequencer picks a phase and pulses `phaseStart`. This loads the counter with the negated ideal total for that phase. The sequencer then streams match pulses while the converter is exercised, and closes each step (one code, or the whole gain range) with `stepEnd`. The result appears one cycle later with a one-cycle `resultValid` strobe. Every result is a signed fixed-point value with P+Z fractional bits, so the value in LSB units is `result / 2^(P+Z)`.

Top module: `histParamAccum`

## Requirements
- R1: After reset `result` is 0 and `resultValid` is 0. A `stepEnd` that arrives before the first `phaseStart` since reset produces no `resultValid`.
- R2: `phaseSel` encodes the phase as follows: 0 offset, 1 gain, 2 DNL, 3 INL. On `phaseStart` the counter is loaded with that phase's start value: 0 for offset, -2^(P+Z) for gain, -2^P for DNL and INL. Match pulses in the `phaseStart` cycle are ignored, and a `stepEnd` in the same cycle produces no result.
- R3: In the offset phase the counter steps up on `matchTop` and down on `matchCode`. When both are high in the same cycle the counter does not change. The result is (top hits - bottom hits) * 2^(Z-1).
- R4: In the gain phase the result is (`matchCode` hits - 2^(P+Z)). `matchTop` has no effect in the gain, DNL and INL phases.
- R5: In the DNL phase the result of each step is (`matchCode` hits in that step - 2^P) * 2^Z. The counter restarts from -2^P for the next step.
- R6: In the INL phase the counter is not cleared between steps. After each step it is lowered by 2^P, so step k yields the sum over steps 1..k of (hits - 2^P), times 2^Z.
- R7: A match pulse in the same cycle as `stepEnd` counts toward the step being closed.
- R8: `resultValid` is high for exactly the one cycle after an accepted `stepEnd`. `result` holds its value until the next accepted `stepEnd`.
- R9: The counter has P+Z+HEAD bits and saturates at its most positive and most negative values, including on the INL carry. It never wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseSel | input | 2 | Phase to start (0 offset, 1 gain, 2 DNL, 3 INL) |
| phaseStart | input | 1 | Load the counter for the phase on `phaseSel` |
| stepEnd | input | 1 | Close the current step and publish its result |
| matchCode | input | 1 | Sample hit the current code (bottom code in offset phase) |
| matchTop | input | 1 | Sample hit the top code (offset phase only) |
| result | output | P+2Z+HEAD | Signed result, P+Z fractional bits |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds the block with P=2, Z=2 and HEAD=3. This gives a 7-bit counter, an ideal count of 4 and a gain total of 16. With these values the bench can sweep every pair of offset hit counts up to 5, gain totals from 0 to 40, and DNL counts across the ideal value. Both saturation limits and the INL negative clamp can be reached within a few dozen pulses. Expected values are computed from the scaling formulas in the requirements.

// File: rtl/histAccPkg.sv
package histAccPkg;

  typedef enum logic [1:0] {
    PH_OFFSET = 2'd0,
    PH_GAIN   = 2'd1,
    PH_DNL    = 2'd2,
    PH_INL    = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   preset;
    logic   capture;
    logic   up;
    logic   down;
    phase_e phase;
  } accStrb_t;

endpackage

// File: rtl/histAccCtrl.sv
module histAccCtrl
  import histAccPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] phaseSel,
  input  logic       phaseStart,
  input  logic       stepEnd,
  input  logic       matchCode,
  input  logic       matchTop,
  output accStrb_t   strb
);

  phase_e curPhase;
  logic   armed;
  phase_e selPhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPhase <= PH_OFFSET;
      armed    <= 1'b0;
    end else if (phaseStart) begin
      curPhase <= phase_e'(phaseSel);
      armed    <= 1'b1;
    end
  end

  always_comb begin
    selPhase     = phaseStart ? phase_e'(phaseSel) : curPhase;
    strb.phase   = selPhase;
    strb.preset  = phaseStart;
    strb.capture = stepEnd & ~phaseStart & armed;
    if (selPhase == PH_OFFSET) begin
      strb.up   = armed & matchTop & ~matchCode;
      strb.down = armed & matchCode & ~matchTop;
    end else begin
      strb.up   = armed & matchCode;
      strb.down = 1'b0;
    end
  end

endmodule

// File: rtl/histAccDatapath.sv
module histAccDatapath
  import histAccPkg::*;
#(
  parameter int P    = 5,
  parameter int Z    = 4,
  parameter int HEAD = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  accStrb_t                        strb,
  output logic signed [P+Z+HEAD+Z-1:0]    result,
  output logic                            resultValid
);

  localparam int ACC_W = P + Z + HEAD;
  localparam int RW    = ACC_W + Z;
  localparam int IDEAL = 1 << P;
  localparam int TOTAL = 1 << (P + Z);
  localparam logic signed [ACC_W-1:0] ACC_MAX   = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN   = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] NEG_IDEAL = ACC_W'(-IDEAL);
  localparam logic signed [ACC_W-1:0] NEG_TOTAL = ACC_W'(-TOTAL);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] stepped;
  logic signed [ACC_W-1:0] presetVal;
  logic signed [ACC_W-1:0] carried;
  logic signed [ACC_W:0]   carryWide;
  logic signed [RW-1:0]    widened;
  logic signed [RW-1:0]    scaled;

  function automatic logic signed [ACC_W-1:0] startOf(phase_e ph);
    case (ph)
      PH_OFFSET: return '0;
      PH_GAIN:   return NEG_TOTAL;
      default:   return NEG_IDEAL;
    endcase
  endfunction

  // saturating up/down step
  always_comb begin
    stepped = acc;
    if (strb.up && acc != ACC_MAX)
      stepped = acc + ACC_W'(1);
    else if (strb.down && acc != ACC_MIN)
      stepped = acc - ACC_W'(1);
  end

  // INL carry: lower by the ideal count, clamp at the negative limit
  always_comb begin
    carryWide = $signed({stepped[ACC_W-1], stepped}) - $signed((ACC_W+1)'(IDEAL));
    if (carryWide[ACC_W] != carryWide[ACC_W-1])
      carried = ACC_MIN;
    else
      carried = carryWide[ACC_W-1:0];
  end

  assign presetVal = startOf(strb.phase);

  // binary-point placement: every result carries P+Z fractional bits
  always_comb begin
    widened = {{Z{stepped[ACC_W-1]}}, stepped};
    case (strb.phase)
      PH_OFFSET: scaled = widened <<< (Z - 1);
      PH_GAIN:   scaled = widened;
      default:   scaled = widened <<< Z;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc         <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.capture;
      if (strb.preset) begin
        acc <= presetVal;
      end else if (strb.capture) begin
        result <= scaled;
        acc    <= (strb.phase == PH_INL) ? carried : presetVal;
      end else begin
        acc <= stepped;
      end
    end
  end

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.preset) && !$past(strb.capture)) |->
      (acc == $past(acc) || acc == $past(acc) + 1 || acc == $past(acc) - 1));

  // R4
  no_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.preset) && !$past(strb.capture) && $past(strb.phase) != PH_OFFSET)
      |-> acc >= $past(acc));

  // R5
  frac_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && ($past(strb.phase) == PH_DNL || $past(strb.phase) == PH_INL))
      |-> result[Z-1:0] == '0);

endmodule

// File: rtl/histParamAccum.sv
module histParamAccum
  import histAccPkg::*;
#(
  parameter int P    = 5,
  parameter int Z    = 4,
  parameter int HEAD = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0]                   phaseSel,
  input  logic                         phaseStart,
  input  logic                         stepEnd,
  input  logic                         matchCode,
  input  logic                         matchTop,
  output logic signed [P+Z+HEAD+Z-1:0] result,
  output logic                         resultValid
);

  accStrb_t strb;

  histAccCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseSel   (phaseSel),
    .phaseStart (phaseStart),
    .stepEnd    (stepEnd),
    .matchCode  (matchCode),
    .matchTop   (matchTop),
    .strb       (strb)
  );

  histAccDatapath #(.P(P), .Z(Z), .HEAD(HEAD)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .result      (result),
    .resultValid (resultValid)
  );

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(stepEnd && !phaseStart));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

endmodule

// File: tb/test_histParamAccum.sv
module test_histParamAccum;

  localparam int P = 2, Z = 2, HEAD = 3;
  localparam int RW = P + Z + HEAD + Z;
  localparam int IDEAL = 1 << P;
  localparam int TOTAL = 1 << (P + Z);
  localparam int AMAX = (1 << (P + Z + HEAD - 1)) - 1;
  localparam int AMIN = -(1 << (P + Z + HEAD - 1));

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] phaseSel = 2'd0;
  logic phaseStart = 0, stepEnd = 0, matchCode = 0, matchTop = 0;
  logic signed [RW-1:0] result;
  logic resultValid;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  histParamAccum #(.P(P), .Z(Z), .HEAD(HEAD)) i_histParamAccum (
    .clk(clk), .rstN(rstN), .phaseSel(phaseSel), .phaseStart(phaseStart),
    .stepEnd(stepEnd), .matchCode(matchCode), .matchTop(matchTop),
    .result(result), .resultValid(resultValid));

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic startPhase(int ph, logic noise);
    @(negedge clk);
    phaseSel = ph[1:0]; phaseStart = 1; matchCode = noise; matchTop = noise;
    @(negedge clk);
    phaseStart = 0; matchCode = 0; matchTop = 0;
  endtask

  task automatic hits(int nBoth, int nCode, int nTop);
    for (int i = 0; i < nBoth; i++) begin
      @(negedge clk); matchCode = 1; matchTop = 1;
    end
    for (int i = 0; i < nCode; i++) begin
      @(negedge clk); matchCode = 1; matchTop = 0;
    end
    for (int i = 0; i < nTop; i++) begin
      @(negedge clk); matchCode = 0; matchTop = 1;
    end
    @(negedge clk); matchCode = 0; matchTop = 0;
  endtask

  task automatic endStep(string tag, int exp, logic hitNow);
    @(negedge clk); stepEnd = 1; matchCode = hitNow;
    @(negedge clk); stepEnd = 0; matchCode = 0;
    check({tag, " valid"}, int'(resultValid), 1);
    check(tag, int'(result), exp);
  endtask

  function automatic int clampAcc(int v);
    return v > AMAX ? AMAX : (v < AMIN ? AMIN : v);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int run;
    repeat (3) @(negedge clk);
    check("R1 reset result", int'(result), 0);
    check("R1 reset valid", int'(resultValid), 0);
    rstN = 1;
    // R1: stepEnd before any phaseStart is ignored
    @(negedge clk); stepEnd = 1;
    @(negedge clk); stepEnd = 0;
    check("R1 unarmed valid", int'(resultValid), 0);

    // R3: offset sweep, coincident pulses cancel
    for (int hi = 0; hi <= 5; hi++)
      for (int lo = 0; lo <= 5; lo++) begin
        startPhase(0, 1'b1);
        hits(hi % 2 + 1, lo, hi);
        endStep("R3 offset", (hi - lo) * (1 << (Z - 1)), 1'b0);
      end
    // R8: strobe lasts one cycle, result holds
    @(negedge clk);
    check("R8 valid drop", int'(resultValid), 0);
    check("R8 hold", int'(result), 0);

    // R4: gain sweep with top pulses that must be ignored
    for (int n = 0; n <= 40; n += 3) begin
      startPhase(1, 1'b1);
      hits(2, n, 3);
      endStep("R4 gain", n + 2 - TOTAL, 1'b0);
    end

    // R5 / R7: DNL steps in one phase, last hit sometimes coincident with stepEnd
    startPhase(2, 1'b1);
    for (int n = 0; n <= 10; n++) begin
      hits(0, n, 2);
      endStep("R5 R7 dnl", (n + (n % 2) - IDEAL) * (1 << Z), logic'(n % 2));
    end

    // R6: INL running sum
    startPhase(3, 1'b0);
    run = 0;
    for (int k = 0; k < 10; k++) begin
      int n = (k * 3) % 9;
      hits(0, n, 1);
      run = run + n - IDEAL;
      endStep("R6 inl", run * (1 << Z), 1'b0);
    end

    // R9: positive clamp in gain, negative clamp in offset
    startPhase(1, 1'b0);
    hits(0, 100, 0);
    endStep("R9 sat high", AMAX, 1'b0);
    startPhase(0, 1'b0);
    hits(0, 70, 0);
    endStep("R9 sat low", AMIN * (1 << (Z - 1)), 1'b0);
    // R9: INL carry clamps at the negative limit
    startPhase(3, 1'b0);
    for (int k = 1; k <= 20; k++)
      endStep("R9 inl clamp", clampAcc(-IDEAL * k) * (1 << Z), 1'b0);

    // R2: phaseStart with coincident stepEnd gives no result and restarts
    startPhase(1, 1'b0);
    hits(0, 5, 0);
    @(negedge clk); phaseSel = 2'd2; phaseStart = 1; stepEnd = 1; matchCode = 1;
    @(negedge clk); phaseStart = 0; stepEnd = 0; matchCode = 0;
    check("R2 start+end valid", int'(resultValid), 0);
    hits(0, 6, 0);
    endStep("R2 fresh dnl", (6 - IDEAL) * (1 << Z), 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule